// File: doc/BRIEF.md
# Cache Invalidate-All Sequencer

This block clears every valid bit of an on-chip cache whose storage can be arranged in one of two ways. In the first, it is two 1 KB arrays, one for instructions and one for data. In the second, it is one 2 KB array that serves only instructions or only data. A single start pulse launches the operation. The sequencer reads two disable bits and two keep bits and decodes which array or arrays must be cleared. It then walks the tag index from zero upward, one line per clock, and drives a clear strobe toward each selected array. When the walk ends it raises a done pulse.

Lines are 16 bytes long. A 1 KB array therefore has 64 indices and the 2 KB arrangement has 128. In the split arrangement, both arrays share one index bus and are cleared side by side over the same cycles. A keep bit protects its side from clearing, so its sense is the reverse of an enable. In either unified arrangement, the keep bits are disregarded. The tag storage itself lies outside this block.

Top module: `cinv_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and both clear strobes are low until a start is accepted.
- R2: With both disable bits low and both keep bits low, a start clears both arrays in parallel: 64 cycles in which both clear strobes are high and the index runs 0 to 63.
- R3: With both disable bits low, setting only the data keep bit clears only the instruction array (64 cycles). Setting only the instruction keep bit clears only the data array (64 cycles).
- R4: With both disable bits low and both keep bits high, no clear strobe is issued, and done is high on the cycle after the start.
- R5: With only the data disable bit high, 128 cycles of instruction clear strobes are issued with index 0 to 127, whatever the keep bits are. The data strobe stays low.
- R6: With only the instruction disable bit high, 128 cycles of data clear strobes are issued with index 0 to 127, whatever the keep bits are. The instruction strobe stays low.
- R7: With both disable bits high, no clear strobe is issued, and done is high on the cycle after the start.
- R8: During a sweep the index starts at 0 in the first cycle after the start and increases by exactly one each cycle.
- R9: Busy is high exactly in the cycles that carry a clear strobe. Done is high for the single cycle after the last clear, and never together with busy.
- R10: A start pulse that arrives while busy is high has no effect on the strobes, the index or the end of the sweep.
- R11: The configuration bits are sampled only when a start is accepted. Changing them during a sweep does not change which strobes are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dis_icache_i | input | 1 | Instruction side disabled (high: unified data cache) |
| dis_dcache_i | input | 1 | Data side disabled (high: unified instruction cache) |
| keep_icache_i | input | 1 | Split mode: high protects the instruction array |
| keep_dcache_i | input | 1 | Split mode: high protects the data array |
| line_idx_o | output | 7 | Line index being cleared |
| clr_icache_o | output | 1 | Clear the valid bit at line_idx_o in the instruction array |
| clr_dcache_o | output | 1 | Clear the valid bit at line_idx_o in the data array |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. The index must step by one while busy. Both strobes together are allowed only below the split depth. The strobe pattern must hold steady through a sweep. Busy must not fall before the last index, and its fall must coincide with done, which never overlaps busy. Only the bench's scenarios can show the rest: that each of the decode combinations selects the right arrays at the right depth, that the unified modes ignore the keep bits, that a start during a sweep is ignored, and that the configuration can change mid-sweep without effect. The bench compares the full strobe stream, cycle by cycle, against an expected list built from the requirements.

// File: rtl/cinv_pkg.sv
package cinv_pkg;

  typedef enum logic [1:0] {
    ARR_SPLIT = 2'd0,
    ARR_UNI_I = 2'd1,
    ARR_UNI_D = 2'd2,
    ARR_NONE  = 2'd3
  } arr_mode_e;

  typedef struct packed {
    logic dis_i;
    logic dis_d;
    logic keep_i;
    logic keep_d;
  } inv_cfg_t;

  typedef struct packed {
    logic sel_i;
    logic sel_d;
    logic wide;
  } inv_plan_t;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SWEEP = 1'b1
  } seq_state_e;

endpackage

// File: rtl/cinv_decode.sv
module cinv_decode
  import cinv_pkg::*;
(
  input  inv_cfg_t  cfg_i,
  output arr_mode_e mode_o,
  output inv_plan_t plan_o
);

  always_comb begin
    unique case ({cfg_i.dis_i, cfg_i.dis_d})
      2'b00:   mode_o = ARR_SPLIT;
      2'b01:   mode_o = ARR_UNI_I;
      2'b10:   mode_o = ARR_UNI_D;
      default: mode_o = ARR_NONE;
    endcase
  end

  always_comb begin
    plan_o = '0;
    unique case (mode_o)
      ARR_SPLIT: begin
        // keep bits are active-high protections
        plan_o.sel_i = ~cfg_i.keep_i;
        plan_o.sel_d = ~cfg_i.keep_d;
        plan_o.wide  = 1'b0;
      end
      ARR_UNI_I: begin
        plan_o.sel_i = 1'b1;
        plan_o.wide  = 1'b1;
      end
      ARR_UNI_D: begin
        plan_o.sel_d = 1'b1;
        plan_o.wide  = 1'b1;
      end
      default: plan_o = '0;
    endcase
  end

endmodule

// File: rtl/cinv_idx_ctr.sv
module cinv_idx_ctr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             at_last_o
);

  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = load_i | step_i;
    if (load_i) idx_d = '0;
    else        idx_d = idx_o + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_o <= '0;
    else if (idx_en) idx_o <= idx_d;
  end

  assign at_last_o = (idx_o == last_i);

  // R8: consecutive stepping while stepping
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (idx_o == $past(idx_o) + IDX_W'(1)));

endmodule

// File: rtl/cinv_seq.sv
module cinv_seq
  import cinv_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int SIDE_BYTES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dis_icache_i,
  input  logic       dis_dcache_i,
  input  logic       keep_icache_i,
  input  logic       keep_dcache_i,
  output logic [6:0] line_idx_o,
  output logic       clr_icache_o,
  output logic       clr_dcache_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int SIDE_LINES = SIDE_BYTES / LINE_BYTES;
  localparam int UNI_LINES  = 2 * SIDE_LINES;
  localparam int IDX_W      = $clog2(UNI_LINES);

  inv_cfg_t   cfg;
  arr_mode_e  mode;
  inv_plan_t  plan;

  seq_state_e       state_q, state_d;
  logic             sel_i_q, sel_i_d;
  logic             sel_d_q, sel_d_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             done_q, done_d;
  logic             cfg_en, ctr_load, ctr_step, at_last;
  logic [IDX_W-1:0] idx;

  assign cfg = '{dis_i: dis_icache_i, dis_d: dis_dcache_i,
                 keep_i: keep_icache_i, keep_d: keep_dcache_i};

  cinv_decode u_decode (
    .cfg_i  (cfg),
    .mode_o (mode),
    .plan_o (plan)
  );

  cinv_idx_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ctr_load),
    .step_i    (ctr_step),
    .last_i    (last_q),
    .idx_o     (idx),
    .at_last_o (at_last)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    sel_i_d  = sel_i_q;
    sel_d_d  = sel_d_q;
    last_d   = last_q;
    done_d   = 1'b0;
    cfg_en   = 1'b0;
    ctr_load = 1'b0;
    ctr_step = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          if (plan.sel_i || plan.sel_d) begin
            cfg_en   = 1'b1;
            ctr_load = 1'b1;
            sel_i_d  = plan.sel_i;
            sel_d_d  = plan.sel_d;
            last_d   = plan.wide ? IDX_W'(UNI_LINES - 1) : IDX_W'(SIDE_LINES - 1);
            state_d  = SEQ_SWEEP;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      SEQ_SWEEP: begin
        ctr_step = ~at_last;
        if (at_last) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_i_q <= 1'b0;
      sel_d_q <= 1'b0;
      last_q  <= '0;
    end else if (cfg_en) begin
      sel_i_q <= sel_i_d;
      sel_d_q <= sel_d_d;
      last_q  <= last_d;
    end
  end

  assign busy_o       = (state_q == SEQ_SWEEP);
  assign clr_icache_o = busy_o & sel_i_q;
  assign clr_dcache_o = busy_o & sel_d_q;
  assign done_o       = done_q;
  assign line_idx_o   = 7'(idx);

  // R2: parallel clears stay within the split depth
  a_r2_split_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_icache_o && clr_dcache_o) |-> (int'(line_idx_o) < SIDE_LINES));

  // R9: completion pulse accompanies the end of busy
  a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10: busy holds until the last index
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (idx != last_q)) |=> busy_o);

  // R11: strobe pattern is frozen for the whole sweep
  a_r11_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || (clr_icache_o == $past(clr_icache_o) &&
                            clr_dcache_o == $past(clr_dcache_o))));

endmodule

// File: tb/test_cinv_seq.sv
`timescale 1ns/1ps
module test_cinv_seq;

  typedef struct {
    bit        is_done;
    int        idx;
    bit        ci;
    bit        cd;
    string     req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       dis_i, dis_d, keep_i, keep_d;
  logic [6:0] idx;
  logic       clr_i, clr_d, busy, done;

  exp_t sbq[$];
  int   n_checks;
  int   n_errors;
  int   cycles;

  cinv_seq i_cinv_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .dis_icache_i  (dis_i),
    .dis_dcache_i  (dis_d),
    .keep_icache_i (keep_i),
    .keep_dcache_i (keep_d),
    .line_idx_o    (idx),
    .clr_icache_o  (clr_i),
    .clr_dcache_o  (clr_d),
    .busy_o        (busy),
    .done_o        (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (busy || clr_i || clr_d || done)
        chk(!(done && busy), "R9", "done with busy", int'(done && busy), 0);
      if (busy)
        chk(clr_i || clr_d, "R9", "busy without strobe", 0, 1);
      if (clr_i || clr_d || done) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R10", "unexpected activity idx", int'(idx), -1);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (e.is_done) begin
            chk(done && !clr_i && !clr_d, e.req, "done pulse", int'({done, clr_i, clr_d}), 4);
          end else begin
            chk(!done, e.req, "early done", int'(done), 0);
            chk(int'(idx) == e.idx, e.req, "index", int'(idx), e.idx);
            chk(clr_i == e.ci && clr_d == e.cd, e.req, "strobes {i,d}",
                int'({clr_i, clr_d}), int'({e.ci, e.cd}));
          end
        end
      end
    end
  end

  task automatic push_exp(input bit di, input bit dd, input bit ki, input bit kd, input string req);
    int n;
    bit ci, cd;
    if (!di && dd)      begin n = 128; ci = 1; cd = 0; end
    else if (di && !dd) begin n = 128; ci = 0; cd = 1; end
    else if (di && dd)  begin n = 0;   ci = 0; cd = 0; end
    else begin
      ci = !ki; cd = !kd;
      n  = (ci || cd) ? 64 : 0;
    end
    for (int k = 0; k < n; k++) sbq.push_back('{0, k, ci, cd, req});
    sbq.push_back('{1, 0, 0, 0, req});
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done && !clr_i && !clr_d, req, "idle after op", int'({busy, done, clr_i, clr_d}), 0);
  endtask

  task automatic run_op(input bit di, input bit dd, input bit ki, input bit kd, input string req);
    @(negedge clk);
    dis_i = di; dis_d = dd; keep_i = ki; keep_d = kd;
    push_exp(di, dd, ki, kd, req);
    pulse_start();
    wait_drain(req);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; cycles = 0;
    rst_n = 1'b0; start = 1'b0;
    dis_i = 1'b0; dis_d = 1'b0; keep_i = 1'b0; keep_d = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !clr_i && !clr_d, "R1", "outputs in reset", int'({busy, done, clr_i, clr_d}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !clr_i && !clr_d, "R1", "outputs after reset", int'({busy, done, clr_i, clr_d}), 0);

    run_op(0, 0, 0, 0, "R2");
    run_op(0, 0, 0, 1, "R3");
    run_op(0, 0, 1, 0, "R3");
    run_op(0, 0, 1, 1, "R4");
    run_op(0, 1, 0, 0, "R5");
    run_op(0, 1, 1, 1, "R5");
    run_op(1, 0, 0, 0, "R6");
    run_op(1, 0, 1, 1, "R6");
    run_op(1, 1, 0, 0, "R7");
    run_op(1, 1, 1, 1, "R7");

    // R8 back-to-back: start accepted in the done cycle of the previous op
    @(negedge clk);
    dis_i = 0; dis_d = 0; keep_i = 1; keep_d = 1;
    push_exp(0, 0, 1, 1, "R8");
    pulse_start();
    dis_i = 0; dis_d = 0; keep_i = 0; keep_d = 1;
    push_exp(0, 0, 0, 1, "R8");
    pulse_start();
    wait_drain("R8");

    // R10: start while busy is ignored
    @(negedge clk);
    dis_i = 1; dis_d = 0; keep_i = 0; keep_d = 0;
    push_exp(1, 0, 0, 0, "R10");
    pulse_start();
    repeat (10) @(negedge clk);
    dis_i = 1; dis_d = 1;
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    // R11: configuration changes during the sweep have no effect
    dis_i = 0; dis_d = 1; keep_i = 1; keep_d = 0;
    repeat (20) @(negedge clk);
    dis_i = 0; dis_d = 0; keep_i = 0; keep_d = 0;
    wait_drain("R11");

    run_op(0, 0, 1, 0, "R11");

    finish_run();
  end

endmodule